// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a small hardware watchdog. An 8-bit counter is loaded with a start value and then counts down once per slow tick. A prescaler derives the tick from the system clock: with the default 17-bit prescaler and a 100 MHz clock, one tick is 131072 clocks, about 763 Hz. One tick before the counter runs out, the block sends a one-cycle non-maskable interrupt request. Software can use that warning to save state. When the counter reaches zero, the block raises a chip reset request. That request stays high until the system reset input is asserted.

Software controls the watchdog with a single control-word write. The word carries a count, a start/stop command and a 7-bit key. Each write is accepted only if its key is the bitwise inverse of the last accepted key. A stray or runaway write is therefore very unlikely to restart or stop the watchdog. A start command also serves as the restart ("kick"). A rejected write changes nothing except a sticky error flag.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the counter is 0, the watchdog is stopped, no reference key is held, and `nmiReq`, `rstReq` and `keyErr` are low.
- R2: While no reference key is held, a start write (`wrCmd`=1) is accepted whatever its key, and that key becomes the reference key. A stop write (`wrCmd`=0) in this state is rejected.
- R3: Once a reference key is held, a write is accepted only if `wrKey` equals the bitwise inverse of the reference key. Each accepted write replaces the reference key with its own key.
- R4: A rejected write leaves the counter, the run state and the reference key unchanged. It sets `keyErr`, which stays set until reset.
- R5: An accepted start loads `wrCount` and clears the prescaler. The first decrement happens on the clock edge 2^PRESC_W cycles after the write edge, and later decrements follow every 2^PRESC_W cycles.
- R6: `nmiReq` is a pulse exactly one cycle long. It is asserted on the same edge on which a tick takes the counter from 2 to 1.
- R7: A tick that finds the counter at 1 or 0 sets the counter to 0, stops counting and asserts `rstReq`. `rstReq` then stays high until `rst_n` is asserted.
- R8: An accepted stop halts counting. While stopped, the counter keeps its value and neither request output is asserted.
- R9: An accepted start while the counter is running reloads the counter with the new `wrCount` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wrEn | input | 1 | Control-word write strobe |
| wrCmd | input | 1 | 1 = start/restart, 0 = stop |
| wrCount | input | CNT_W | Start value for the counter |
| wrKey | input | KEY_W | Key presented with the write |
| nmiReq | output | 1 | One-cycle non-maskable interrupt request |
| rstReq | output | 1 | Chip reset request, held until reset |
| keyErr | output | 1 | Sticky flag: a write was rejected |
| running | output | 1 | Counter is counting |
| count | output | CNT_W | Current counter value |

## Verification
The assertions check four things on every cycle:
- `nmiReq` never lasts more than one cycle, and `rstReq` never falls outside reset.
- The counter steps down by at most one, and never moves while stopped.
- A rejected write never alters the reference key, and `keyErr` never clears.
- A reset request only follows a counter value of 1 or 0.

Only the bench scenarios can show the rest: the exact cycle of each warning and reset after a load, whether a given key inversion is accepted, and that a reload really restarts the countdown.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  typedef enum logic {
    CMD_STOP  = 1'b0,
    CMD_START = 1'b1
  } kwdCmd_e;

  typedef struct packed {
    logic load;
    logic halt;
  } kwdStb_t;

endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             wrCmd,
  input  logic [KEY_W-1:0] wrKey,
  output kwdStb_t          stb,
  output logic             keyErr
);

  logic [KEY_W-1:0] refKey;
  logic             haveKey;
  logic             keyOk;
  logic             accept;

  always_comb begin
    if (haveKey) keyOk = (wrKey == ~refKey);
    else         keyOk = (kwdCmd_e'(wrCmd) == CMD_START);
    accept   = wrEn && keyOk;
    stb.load = accept && (kwdCmd_e'(wrCmd) == CMD_START);
    stb.halt = accept && (kwdCmd_e'(wrCmd) == CMD_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refKey  <= '0;
      haveKey <= 1'b0;
      keyErr  <= 1'b0;
    end else if (wrEn) begin
      if (accept) begin
        refKey  <= wrKey;
        haveKey <= 1'b1;
      end else begin
        keyErr  <= 1'b1;
      end
    end
  end

  AST_BAD_KEY_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !accept) |=> $stable(refKey)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    keyErr |=> keyErr); // R4
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.load && stb.halt)); // R3

endmodule

// File: rtl/kwd_dp.sv
module kwd_dp
  import kwd_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRESC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  kwdStb_t          stb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntQ,
  output logic             runQ,
  output logic             nmiReq,
  output logic             rstReq
);

  localparam logic [CNT_W-1:0]   CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0]   CNT_TWO  = CNT_W'(2);
  localparam logic [PRESC_W-1:0] PRESC_MAX = '1;

  logic [PRESC_W-1:0] presc;
  logic               tick;

  assign tick = runQ && (presc == PRESC_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc  <= '0;
      cntQ   <= '0;
      runQ   <= 1'b0;
      nmiReq <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      nmiReq <= 1'b0;
      if (stb.load) begin
        cntQ  <= loadVal;
        presc <= '0;
        runQ  <= 1'b1;
      end else if (stb.halt) begin
        presc <= '0;
        runQ  <= 1'b0;
      end else if (runQ) begin
        presc <= presc + 1'b1;
        if (tick) begin
          if (cntQ > CNT_ONE) begin
            cntQ <= cntQ - 1'b1;
            if (cntQ == CNT_TWO) nmiReq <= 1'b1;
          end else begin
            cntQ   <= '0;
            runQ   <= 1'b0;
            rstReq <= 1'b1;
          end
        end
      end
    end
  end

  AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmiReq |=> !nmiReq); // R6
  AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |=> rstReq); // R7
  AST_RST_FROM_LOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstReq) |-> ($past(cntQ) <= CNT_ONE)); // R7
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!runQ && !stb.load) |=> $stable(cntQ)); // R8
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && !stb.load) |=> (cntQ == $past(cntQ)) || (cntQ == $past(cntQ) - 1'b1)); // R5

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int KEY_W   = 7,
  parameter int PRESC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             wrCmd,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [KEY_W-1:0] wrKey,
  output logic             nmiReq,
  output logic             rstReq,
  output logic             keyErr,
  output logic             running,
  output logic [CNT_W-1:0] count
);

  kwdStb_t stb;

  kwd_ctrl #(.KEY_W(KEY_W)) uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrCmd  (wrCmd),
    .wrKey  (wrKey),
    .stb    (stb),
    .keyErr (keyErr)
  );

  kwd_dp #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .loadVal (wrCount),
    .cntQ    (count),
    .runQ    (running),
    .nmiReq  (nmiReq),
    .rstReq  (rstReq)
  );

endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;

  localparam int P = 4;
  localparam int T = 1 << P;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrCmd = 1'b0;
  logic [7:0] wrCount = '0;
  logic [6:0] wrKey = '0;
  logic       nmiReq, rstReq, keyErr, running;
  logic [7:0] count;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit doneFlag = 0;

  typedef struct packed { logic [31:0] kind; logic [31:0] at; } ev_t;
  ev_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_wdog #(.CNT_W(8), .KEY_W(7), .PRESC_W(P)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrCmd(wrCmd), .wrCount(wrCount),
    .wrKey(wrKey), .nmiReq(nmiReq), .rstReq(rstReq), .keyErr(keyErr),
    .running(running), .count(count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectEv(input int kind, input int at);
    ev_t e;
    e.kind = kind;
    e.at = at;
    q.push_back(e);
  endtask

  task automatic wr(input bit cmd, input int cnt, input int key, output int edgeCyc);
    @(negedge clk);
    wrEn = 1'b1; wrCmd = cmd; wrCount = 8'(cnt); wrKey = 7'(key);
    @(posedge clk);
    #1 edgeCyc = cyc;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: scoreboard for request events (kind 0 = nmi, 1 = rst)
  initial begin
    bit pn = 0;
    bit pr = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (nmiReq && pn) chk(0, "R6 nmi wider than one cycle", 2, 1);
        if ((nmiReq && !pn) || (rstReq && !pr)) begin
          int kind;
          kind = (nmiReq && !pn) ? 0 : 1;
          if (q.size() == 0) chk(0, "R6/R7 unexpected request", kind, -1);
          else begin
            ev_t e;
            e = q.pop_front();
            chk(int'(e.kind) == kind, "R6/R7 request kind", kind, int'(e.kind));
            chk(int'(e.at) == cyc, "R5/R6/R7 request cycle", cyc, int'(e.at));
          end
        end
        pn = nmiReq;
        pr = rstReq;
      end else begin
        pn = 0;
        pr = 0;
      end
    end
  end

  initial begin
    repeat (6000) @(posedge clk);
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e, e1, e2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1 count", count, 0);
    chk(!running, "R1 running", running, 0);
    chk(!nmiReq && !rstReq, "R1 requests", {nmiReq, rstReq}, 0);
    chk(!keyErr, "R1 keyErr", keyErr, 0);

    // R2 stop before any key rejected; start then accepted with any key
    wr(0, 7, 5, e);
    chk(keyErr, "R2 stop before key rejected", keyErr, 1);
    chk(!running && count == 0, "R4 rejected keeps state", count, 0);
    wr(1, 3, 8'h2A, e);
    expectEv(0, e + 2*T);
    expectEv(1, e + 3*T);
    chk(running && count == 3, "R2 first start loads", count, 3);
    waitCyc(e + T - 1);
    chk(count == 3, "R5 no decrement before full tick", count, 3);
    waitCyc(e + T);
    chk(count == 2, "R5 first decrement", count, 2);
    waitCyc(e + 3*T + 20);
    chk(rstReq && count == 0 && !running, "R7 bite state", count, 0);
    chk(q.size() == 0, "R6/R7 events seen", q.size(), 0);
    doReset();

    // R3/R4 wrong key ignored, R9 reload with correct inverse key
    wr(1, 5, 8'h15, e1);
    wr(1, 9, 8'h15, e);
    chk(count == 5 && running, "R4 wrong key ignored", count, 5);
    chk(keyErr, "R4 keyErr set", keyErr, 1);
    wr(1, 4, 8'h6A, e2);
    chk(count == 4, "R9 restart reloads", count, 4);
    expectEv(0, e2 + 3*T);
    expectEv(1, e2 + 4*T);
    waitCyc(e2 + 4*T + 10);
    chk(keyErr, "R4 keyErr sticky", keyErr, 1);
    chk(q.size() == 0, "R9 events seen", q.size(), 0);
    doReset();

    // R8 stop with correct key holds counter
    wr(1, 2, 8'h01, e1);
    wr(0, 0, 8'h7E, e);
    chk(!running, "R8 stop accepted", running, 0);
    waitCyc(e + 100);
    chk(count == 2 && !rstReq, "R8 count holds while stopped", count, 2);
    wr(1, 2, 8'h01, e2);
    chk(running && !keyErr, "R3 inverse key accepted", keyErr, 0);
    expectEv(0, e2 + T);
    expectEv(1, e2 + 2*T);
    waitCyc(e2 + 2*T + 10);
    chk(q.size() == 0, "R8 events after restart", q.size(), 0);
    doReset();

    // R3 stop with same (non-inverted) key is rejected
    wr(1, 3, 8'h10, e1);
    wr(0, 0, 8'h10, e);
    chk(running && keyErr, "R3 wrong-key stop ignored", running, 1);
    expectEv(0, e1 + 2*T);
    expectEv(1, e1 + 3*T);
    waitCyc(e1 + 3*T + 10);
    chk(rstReq, "R7 rstReq held", rstReq, 1);
    chk(q.size() == 0, "R7 events seen", q.size(), 0);

    doReset();
    @(negedge clk);
    chk(!rstReq, "R7 released by reset", rstReq, 0);

    doneFlag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule